// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is a two-wire bus target that fronts a small byte-wide memory held in on-chip registers. It runs on a fast system clock. It oversamples the bus clock and data lines and recognises start, repeated start and stop conditions. It also decodes a 7-bit device address followed by a direction bit.

A single address pointer persists across transactions and steps past every byte that is read or written. A master can use the pointer in three ways:

- **Current-address read:** read from wherever the pointer now stands.
- **Random read:** load the pointer with a two-byte word address in write direction, then issue a repeated start and read.
- **Sequential read:** acknowledge each byte to keep streaming.

A write loads the pointer and accepts one data byte. The byte is committed when the stop arrives. The commit starts a modelled internal write cycle of a parameterised number of clocks. During that cycle the target refuses its own address, so the master can poll for completion.

Top module: `serial_mem_target`

## Requirements
- R1: After reset the target releases SDA, the pointer is 0 and every storage byte is 0, so a current-address read straight after reset returns 0x00.
- R2: A control byte whose upper 7 bits equal DEV_ADDR (default 0x50, so 0xA0 writes and 0xA1 reads) is acknowledged when no write cycle is running. Any other address is not acknowledged, and every later byte up to the next start or stop is ignored without acknowledge.
- R3: In write direction the next two bytes form a 12-bit word address, high byte first. Each is acknowledged, and the upper 4 bits of the high byte are ignored.
- R4: The first data byte after the word address is acknowledged and stored at the pointer when the stop arrives, and the pointer then becomes that address plus 1. Further data bytes in the same transaction are not acknowledged and are not stored.
- R5: A stop that commits a data byte starts a write cycle of WR_CYCLES clocks. During the cycle the control byte is not acknowledged; after it the control byte is acknowledged again.
- R6: A current-address read acknowledges the control byte, returns the byte at the pointer and advances the pointer by one.
- R7: A repeated start after the word address sets the pointer without storing anything or starting a write cycle. The following read-direction control byte reads from the new address. A stop straight after the word address behaves the same.
- R8: In a read, a master acknowledge makes the target send the byte at the next address. A master not-acknowledge ends transmission with SDA released.
- R9: The pointer wraps from 0xFFF to 0x000. Storage is indexed by the low MEM_AW bits of the pointer.
- R10: The target changes SDA only while SCL is low. It sends data MSB first and never pulls SDA low while the master drives a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain enable) |

## Verification
The bench covers these patterns:

- Writes followed by an immediate poll and a delayed poll. These separate a running write cycle from an idle one.
- Random, current-address and sequential reads over the same stored bytes. These show whether the pointer update belongs to the read, the write or the address load.
- A foreign device address followed by a current read. This separates an ignored transaction from one that moved the pointer.
- A read across 0xFFF with a nonzero upper nibble in the address. This exposes wrap and masking errors.
- A double data byte and an address-only write. These show whether extra bytes are dropped and whether a write cycle starts without data.

// File: rtl/smt_pkg.sv
package smt_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic sclLvl;
    logic sdaLvl;
    logic sclRise;
    logic sclFall;
    logic startEv;
    logic stopEv;
  } busEv_t;

  typedef struct packed {
    logic shiftIn;   // sample one received bit
    logic countBit;  // count one transmitted bit
    logic shiftTx;   // present the next transmit bit
    logic clrBits;   // restart the bit counter
    logic loadTx;    // fetch byte at pointer, step pointer
    logic holdHi;    // keep high address byte
    logic setPtr;    // load pointer from address bytes
    logic holdData;  // keep received write data
    logic writeMem;  // commit write data, step pointer, start cycle
  } strobes_t;
endpackage

// File: rtl/smt_bus_events.sv
module smt_bus_events
  import smt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclIn,
  input  logic   sdaIn,
  output busEv_t ev
);
  logic [SYNC_STAGES-1:0] sclSh;
  logic [SYNC_STAGES-1:0] sdaSh;
  logic sclPrev;
  logic sdaPrev;
  logic sclNow;
  logic sdaNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSh   <= '1;
      sdaSh   <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSh[0] <= sclIn;
      sdaSh[0] <= sdaIn;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sclSh[i] <= sclSh[i-1];
        sdaSh[i] <= sdaSh[i-1];
      end
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow = sclSh[SYNC_STAGES-1];
  assign sdaNow = sdaSh[SYNC_STAGES-1];

  always_comb begin
    ev.sclLvl  = sclNow;
    ev.sdaLvl  = sdaNow;
    ev.sclRise = sclNow & ~sclPrev;
    ev.sclFall = ~sclNow & sclPrev;
    ev.startEv = sclNow & sclPrev & sdaPrev & ~sdaNow;
    ev.stopEv  = sclNow & sclPrev & ~sdaPrev & sdaNow;
  end
endmodule

// File: rtl/smt_ctrl.sv
module smt_ctrl
  import smt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEv_t            ev,
  input  logic              byteFull,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txMsb,
  input  logic              busy,
  output strobes_t          strb,
  output logic              sdaOe
);
  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} state_e;
  typedef enum logic [1:0] {K_CTRL, K_AHI, K_ALO, K_DATA} kind_e;

  state_e st, stN;
  kind_e  kind, kindN;
  logic   pending, pendN;
  logic   mAck, mAckN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= S_IDLE;
      kind    <= K_CTRL;
      pending <= 1'b0;
      mAck    <= 1'b0;
    end else begin
      st      <= stN;
      kind    <= kindN;
      pending <= pendN;
      mAck    <= mAckN;
    end
  end

  always_comb begin
    strb  = '0;
    stN   = st;
    kindN = kind;
    pendN = pending;
    mAckN = mAck;
    if (ev.stopEv) begin
      stN   = S_IDLE;
      pendN = 1'b0;
      if (pending) strb.writeMem = 1'b1;
    end else if (ev.startEv) begin
      stN          = S_RX;
      kindN        = K_CTRL;
      pendN        = 1'b0;
      strb.clrBits = 1'b1;
    end else begin
      case (st)
        S_RX: begin
          if (ev.sclRise && !byteFull) begin
            strb.shiftIn = 1'b1;
          end else if (ev.sclFall && byteFull) begin
            strb.clrBits = 1'b1;
            case (kind)
              K_CTRL: stN = (rxByte[BYTE_W-1:1] == DEV_ADDR && !busy) ? S_ACK : S_IDLE;
              K_AHI: begin
                strb.holdHi = 1'b1;
                stN = S_ACK;
              end
              K_ALO: begin
                strb.setPtr = 1'b1;
                stN = S_ACK;
              end
              default: begin
                if (!pending) begin
                  strb.holdData = 1'b1;
                  pendN = 1'b1;
                  stN = S_ACK;
                end else begin
                  stN = S_IDLE;
                end
              end
            endcase
          end
        end
        S_ACK: begin
          if (ev.sclFall) begin
            case (kind)
              K_CTRL: begin
                if (rxByte[0]) begin
                  strb.loadTx = 1'b1;
                  stN = S_TX;
                end else begin
                  stN = S_RX;
                  kindN = K_AHI;
                end
              end
              K_AHI: begin
                stN = S_RX;
                kindN = K_ALO;
              end
              default: begin
                stN = S_RX;
                kindN = K_DATA;
              end
            endcase
          end
        end
        S_TX: begin
          if (ev.sclRise) begin
            strb.countBit = 1'b1;
          end else if (ev.sclFall) begin
            if (byteFull) begin
              strb.clrBits = 1'b1;
              stN = S_MACK;
            end else begin
              strb.shiftTx = 1'b1;
            end
          end
        end
        S_MACK: begin
          if (ev.sclRise) begin
            mAckN = ~ev.sdaLvl;
          end else if (ev.sclFall) begin
            if (mAck) begin
              strb.loadTx = 1'b1;
              stN = S_TX;
            end else begin
              stN = S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaOe = (st == S_ACK) || (st == S_TX && !txMsb);
endmodule

// File: rtl/smt_datapath.sv
module smt_datapath
  import smt_pkg::*;
#(
  parameter int PTR_W     = 12,
  parameter int MEM_AW    = 6,
  parameter int WR_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic              sdaBit,
  output logic              byteFull,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic              busy
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int HI_W  = PTR_W - BYTE_W;
  localparam int BIT_W = $clog2(BYTE_W + 1);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] wData;
  logic [HI_W-1:0]   hiAddr;
  logic [PTR_W-1:0]  ptr;
  logic [BIT_W-1:0]  bitCnt;
  logic [CNT_W-1:0]  busyCnt;
  logic [MEM_AW-1:0] memIdx;

  assign memIdx = ptr[MEM_AW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      shiftReg <= '0;
      wData    <= '0;
      hiAddr   <= '0;
      ptr      <= '0;
      bitCnt   <= '0;
      busyCnt  <= '0;
    end else begin
      if (strb.clrBits) bitCnt <= '0;
      else if (strb.shiftIn || strb.countBit) bitCnt <= bitCnt + 1'b1;

      if (strb.shiftIn) shiftReg <= {shiftReg[BYTE_W-2:0], sdaBit};
      else if (strb.shiftTx) shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
      else if (strb.loadTx) shiftReg <= mem[memIdx];

      if (strb.holdHi) hiAddr <= shiftReg[HI_W-1:0];
      if (strb.holdData) wData <= shiftReg;

      if (strb.setPtr) ptr <= {hiAddr, shiftReg};
      else if (strb.loadTx || strb.writeMem) ptr <= ptr + 1'b1;

      if (strb.writeMem) mem[memIdx] <= wData;

      if (strb.writeMem) busyCnt <= CNT_W'(WR_CYCLES);
      else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
    end
  end

  assign byteFull = (bitCnt == BIT_W'(BYTE_W));
  assign rxByte   = shiftReg;
  assign txMsb    = shiftReg[BYTE_W-1];
  assign busy     = (busyCnt != '0);
endmodule

// File: rtl/serial_mem_target.sv
module serial_mem_target
  import smt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         PTR_W       = 12,
  parameter int         MEM_AW      = 6,
  parameter int         WR_CYCLES   = 1000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);
  busEv_t            ev;
  strobes_t          strb;
  logic              byteFull;
  logic [BYTE_W-1:0] rxByte;
  logic              txMsb;
  logic              busy;

  smt_bus_events #(.SYNC_STAGES(SYNC_STAGES)) events_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ev(ev)
  );

  smt_ctrl #(.DEV_ADDR(DEV_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .ev(ev), .byteFull(byteFull), .rxByte(rxByte),
    .txMsb(txMsb), .busy(busy), .strb(strb), .sdaOe(sdaOe)
  );

  smt_datapath #(.PTR_W(PTR_W), .MEM_AW(MEM_AW), .WR_CYCLES(WR_CYCLES)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaBit(ev.sdaLvl), .byteFull(byteFull),
    .rxByte(rxByte), .txMsb(txMsb), .busy(busy)
  );
endmodule

// File: rtl/serial_mem_target_chk.sv
module serial_mem_target_chk
  import smt_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     sdaOe,
  input busEv_t   ev,
  input strobes_t strb,
  input logic     busy
);
  // R10: drive changes happen only in the low phase of the synchronised clock
  p_sda_low_phase_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !ev.sclLvl);

  // R4: data is committed only on a stop condition
  p_commit_on_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeMem |-> ev.stopEv);

  // R5: a commit is followed by the busy window
  p_commit_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeMem |=> busy);

  // R5: the busy window opens only right after a stop
  p_busy_from_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(ev.stopEv));

  // R5: no read byte is fetched during a write cycle
  p_no_read_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadTx |-> !busy);
endmodule

bind serial_mem_target serial_mem_target_chk chk_i (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .ev(ev), .strb(strb), .busy(busy)
);

// File: tb/serial_mem_target_tb.sv
module serial_mem_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 5;
  localparam int WR = 300;
  localparam int MAW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe;
  logic sdaLine;
  logic masterOwns = 1'b0;
  int compared = 0;
  int mismatched = 0;

  logic [7:0]  refMem [1 << MAW];
  logic [11:0] refPtr;

  assign sdaLine = sdaM & ~sdaOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_mem_target #(.WR_CYCLES(WR)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe)
  );

  // R10: compared every clock while the master owns the data line
  always @(negedge clk) begin
    if (rstN && masterOwns) begin
      compared++;
      if (sdaOe) begin
        mismatched++;
        $display("FAIL R10 target drives during master bit: actual 1 expected 0");
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic writeBit(input logic v);
    sdaM = v; tick(QTR);
    sclM = 1'b1; masterOwns = 1'b1; tick(2*QTR);
    masterOwns = 1'b0; sclM = 1'b0; tick(QTR);
  endtask

  task automatic readBit(output logic v);
    sdaM = 1'b1; tick(QTR);
    sclM = 1'b1; tick(QTR);
    v = sdaLine; tick(QTR);
    sclM = 1'b0; tick(QTR);
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(QTR);
    sclM = 1'b1; tick(QTR);
    sdaM = 1'b0; tick(QTR);
    sclM = 1'b0; tick(QTR);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(QTR);
    sclM = 1'b1; tick(QTR);
    sdaM = 1'b1; tick(QTR);
  endtask

  task automatic sendByte(input logic [7:0] b, output int ack);
    logic a;
    for (int i = 7; i >= 0; i--) writeBit(b[i]);
    readBit(a);
    ack = (a == 1'b0) ? 1 : 0;
  endtask

  task automatic recvByte(output logic [7:0] b, input logic giveAck);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      readBit(v);
      b[i] = v;
    end
    writeBit(!giveAck);
  endtask

  function automatic int mdlRead();
    int v = refMem[refPtr[MAW-1:0]];
    refPtr = refPtr + 12'd1;
    return v;
  endfunction

  task automatic poll(input string tag, input int exp);
    int a;
    busStart(); sendByte(8'hA0, a); chk(tag, a, exp); busStop();
  endtask

  task automatic writeOne(input logic [11:0] addr, input logic [7:0] data);
    int a;
    busStart();
    sendByte(8'hA0, a); chk("R2 write control ack", a, 1);
    sendByte({4'h0, addr[11:8]}, a); chk("R3 high address ack", a, 1);
    sendByte(addr[7:0], a); chk("R3 low address ack", a, 1);
    sendByte(data, a); chk("R4 data ack", a, 1);
    busStop();
    refMem[addr[MAW-1:0]] = data;
    refPtr = addr + 12'd1;
    poll("R5 nack during write cycle", 0);
    tick(WR + 60);
    poll("R5 ack after write cycle", 1);
  endtask

  task automatic currentRead(input string tag);
    int a;
    logic [7:0] b;
    busStart();
    sendByte(8'hA1, a); chk({tag, " control ack"}, a, 1);
    recvByte(b, 1'b0);
    chk(tag, b, mdlRead());
    busStop();
  endtask

  task automatic randomRead(input logic [7:0] hi, input logic [7:0] lo, input int n, input string tag);
    int a;
    logic [7:0] b;
    busStart();
    sendByte(8'hA0, a); chk("R2 dummy write ack", a, 1);
    sendByte(hi, a); chk("R3 high address ack", a, 1);
    sendByte(lo, a); chk("R3 low address ack", a, 1);
    refPtr = {hi[3:0], lo};
    busStart();
    sendByte(8'hA1, a); chk("R7 read control ack after repeated start", a, 1);
    for (int k = 0; k < n; k++) begin
      recvByte(b, k < n - 1);
      chk(tag, b, mdlRead());
    end
    busStop();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int a;
    for (int i = 0; i < (1 << MAW); i++) refMem[i] = 8'h00;
    refPtr = 12'h000;
    tick(5);
    chk("R1 SDA released in reset", sdaOe, 0);
    rstN = 1'b1;
    tick(10);
    chk("R1 SDA released after reset", sdaOe, 0);

    currentRead("R1 R6 read at reset pointer");

    writeOne(12'h010, 8'hA5);
    writeOne(12'h011, 8'h3C);
    writeOne(12'h012, 8'hC3);
    writeOne(12'hFFF, 8'h77);
    writeOne(12'h000, 8'h11);

    randomRead(8'h00, 8'h10, 1, "R7 random read data");
    currentRead("R6 current read after random");
    randomRead(8'h00, 8'h10, 4, "R8 sequential read data");
    tick(4);
    chk("R8 SDA released after master nack", sdaOe, 0);

    // R2: foreign address and the bytes after it are ignored
    busStart();
    sendByte(8'hA4, a); chk("R2 foreign address nack", a, 0);
    sendByte(8'h00, a); chk("R2 byte after foreign address nack", a, 0);
    sendByte(8'h10, a); chk("R2 byte after foreign address nack", a, 0);
    sendByte(8'h99, a); chk("R2 byte after foreign address nack", a, 0);
    busStop();
    currentRead("R2 pointer kept after foreign address");
    randomRead(8'h00, 8'h10, 1, "R2 storage kept after foreign address");

    randomRead(8'hF0, 8'h11, 1, "R3 upper nibble ignored");
    randomRead(8'h0F, 8'hFF, 2, "R9 wrap from top address");

    // R4: second data byte refused and dropped
    busStart();
    sendByte(8'hA0, a); chk("R2 write control ack", a, 1);
    sendByte(8'h00, a); chk("R3 high address ack", a, 1);
    sendByte(8'h20, a); chk("R3 low address ack", a, 1);
    sendByte(8'h55, a); chk("R4 first data ack", a, 1);
    sendByte(8'h66, a); chk("R4 second data nack", a, 0);
    busStop();
    refMem[8'h20 & 8'h3F] = 8'h55;
    poll("R5 nack during write cycle", 0);
    tick(WR + 60);
    randomRead(8'h00, 8'h20, 2, "R4 only first byte stored");

    // R7: address only, then stop: no write cycle, pointer moved
    busStart();
    sendByte(8'hA0, a); chk("R2 write control ack", a, 1);
    sendByte(8'h00, a); chk("R3 high address ack", a, 1);
    sendByte(8'h30, a); chk("R3 low address ack", a, 1);
    busStop();
    refPtr = 12'h030;
    poll("R7 no write cycle without data", 1);
    currentRead("R7 pointer set by address only");
    currentRead("R6 pointer stepped by read");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule